// File: doc/BRIEF.md
# Proportional Thermal Throttle Controller

This block is a periodic passive-cooling controller. Each time a temperature sample is strobed in, it forms a correction from two terms. The rate term is one coefficient times the rise in temperature since the previous strobed sample. The error term is a second coefficient times the excess of the current sample over a target temperature. The correction is subtracted from the performance level held so far, and the result is clamped to a percentage between 0 and 100. The percentage is meant to drive a duty-cycle clock throttler.

Both coefficients are signed fixed-point inputs that the surrounding system programs. Choosing the coefficients is left to that system. A two-state machine handles the first sample after reset. In state ST_PRIME no previous sample exists yet. On the first strobe (transition FIRST_SAMPLE) the block moves to ST_TRACK. It stays in ST_TRACK on every later strobe (transition UPDATE), and only reset sends it back to ST_PRIME.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `perf_pct` is 100 and `perf_valid` is 0, and the controller is in ST_PRIME.
- R2: The correction is (K_rate*(T - T_prev) + K_err*(T - T_target)) / 16, rounded toward zero. Each coefficient is an 8-bit two's complement value with 4 fractional bits. Temperatures are 10-bit unsigned values.
- R3: On each strobe the new performance level is the previous level minus the correction. With both coefficients zero, the level does not change.
- R4: The performance level is saturated. A result below 0 gives 0 and a result above 100 gives 100, so `perf_pct` never exceeds 100.
- R5: The first strobe after reset uses its own sample as T_prev, so the rate term is zero for that update (FIRST_SAMPLE, ST_PRIME to ST_TRACK).
- R6: T_prev is the sample taken at the previous strobe. Changes on `temp_in` without a strobe have no effect on the output or on the next update.
- R7: `perf_valid` is high for exactly the one cycle after each strobe cycle, and `perf_pct` changes only in that cycle.
- R8: The coefficients and the target are used only in a strobe cycle. Changing them between strobes has no effect on `perf_pct`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Strobe marking a new temperature sample |
| temp_in | input | 10 | Current temperature sample, unsigned |
| target_temp | input | 10 | Target temperature, unsigned |
| coef_rate | input | 8 | Signed rate coefficient, 4 fractional bits |
| coef_err | input | 8 | Signed error coefficient, 4 fractional bits |
| perf_pct | output | 7 | Performance percentage, 0 to 100 |
| perf_valid | output | 1 | Pulses for one cycle when a new level is shown |

## Verification
The new level and the valid pulse both come from one register stage. They are therefore due at the first rising edge after the cycle in which the strobe is high, and not at any other time. The bench changes every input on a falling edge and samples the outputs on the next falling edge, half a period after the edge that loads the result. Between strobes it changes the temperature, the target and the coefficients. It then waits two whole cycles and confirms that the outputs hold and that the next update still uses the last strobed sample.

// File: rtl/thr_pkg.sv
package thr_pkg;
    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_TRACK = 1'b1
    } thr_state_e;
endpackage

// File: rtl/thr_correction.sv
module thr_correction #(
    parameter int TEMP_W = 10,
    parameter int COEF_W = 8,
    parameter int FRAC   = 4,
    localparam int D_W   = TEMP_W + 1,
    localparam int P_W   = COEF_W + D_W,
    localparam int S_W   = P_W + 1
) (
    input  logic [TEMP_W-1:0]        temp_cur,
    input  logic [TEMP_W-1:0]        temp_prev,
    input  logic [TEMP_W-1:0]        temp_tgt,
    input  logic signed [COEF_W-1:0] k_rate,
    input  logic signed [COEF_W-1:0] k_err,
    output logic signed [S_W-1:0]    corr
);
    logic signed [D_W-1:0] delta;
    logic signed [D_W-1:0] error;
    logic signed [P_W-1:0] prod_rate;
    logic signed [P_W-1:0] prod_err;
    logic signed [S_W-1:0] sum;

    always_comb begin
        delta     = $signed({1'b0, temp_cur}) - $signed({1'b0, temp_prev});
        error     = $signed({1'b0, temp_cur}) - $signed({1'b0, temp_tgt});
        prod_rate = P_W'(k_rate) * P_W'(delta);
        prod_err  = P_W'(k_err) * P_W'(error);
        sum       = S_W'(prod_rate) + S_W'(prod_err);
    end

    generate
        if (FRAC == 0) begin : g_integer
            assign corr = sum;
        end else begin : g_fixed
            localparam logic signed [S_W-1:0] BIAS = S_W'((1 << FRAC) - 1);
            logic signed [S_W-1:0] biased;
            // a negative sum is biased up first, so the shift rounds toward zero
            assign biased = sum[S_W-1] ? (sum + BIAS) : sum;
            assign corr   = biased >>> FRAC;
        end
    endgenerate
endmodule

// File: rtl/thr_clamp.sv
module thr_clamp #(
    parameter int S_W      = 20,
    parameter int PERF_MAX = 100,
    localparam int PERF_W  = $clog2(PERF_MAX + 1),
    localparam int X_W     = S_W + 2
) (
    input  logic [PERF_W-1:0]     perf_old,
    input  logic signed [S_W-1:0] corr,
    output logic [PERF_W-1:0]     perf_new
);
    localparam logic signed [X_W-1:0] MAX_S = X_W'(PERF_MAX);
    logic signed [X_W-1:0] diff;

    always_comb begin
        diff = $signed({{(X_W - PERF_W){1'b0}}, perf_old}) - X_W'(corr);
        if (diff < 0)
            perf_new = '0;
        else if (diff > MAX_S)
            perf_new = PERF_W'(PERF_MAX);
        else
            perf_new = diff[PERF_W-1:0];
    end
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int TEMP_W   = 10,
    parameter int COEF_W   = 8,
    parameter int FRAC     = 4,
    parameter int PERF_MAX = 100,
    localparam int PERF_W  = $clog2(PERF_MAX + 1),
    localparam int S_W     = COEF_W + TEMP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic [TEMP_W-1:0]        temp_in,
    input  logic [TEMP_W-1:0]        target_temp,
    input  logic signed [COEF_W-1:0] coef_rate,
    input  logic signed [COEF_W-1:0] coef_err,
    output logic [PERF_W-1:0]        perf_pct,
    output logic                     perf_valid
);
    thr_state_e            state, state_nx;
    logic [TEMP_W-1:0]     prev_temp;
    logic [TEMP_W-1:0]     prev_use;
    logic signed [S_W-1:0] corr;
    logic [PERF_W-1:0]     perf_nx;

    always_comb begin
        state_nx = state;
        prev_use = prev_temp;
        unique case (state)
            ST_PRIME: begin
                prev_use = temp_in;
                if (sample_valid) state_nx = ST_TRACK;
            end
            ST_TRACK: begin
                prev_use = prev_temp;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nx;
    end

    thr_correction #(
        .TEMP_W(TEMP_W), .COEF_W(COEF_W), .FRAC(FRAC)
    ) u_corr (
        .temp_cur (temp_in),
        .temp_prev(prev_use),
        .temp_tgt (target_temp),
        .k_rate   (coef_rate),
        .k_err    (coef_err),
        .corr     (corr)
    );

    thr_clamp #(
        .S_W(S_W), .PERF_MAX(PERF_MAX)
    ) u_clamp (
        .perf_old(perf_pct),
        .corr    (corr),
        .perf_new(perf_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perf_pct   <= PERF_W'(PERF_MAX);
            prev_temp  <= '0;
            perf_valid <= 1'b0;
        end else begin
            perf_valid <= sample_valid;
            if (sample_valid) begin
                perf_pct  <= perf_nx;
                prev_temp <= temp_in;
            end
        end
    end
endmodule

// File: rtl/thr_ctrl_checker.sv
module thr_ctrl_checker #(
    parameter int COEF_W   = 8,
    parameter int PERF_MAX = 100,
    localparam int PERF_W  = $clog2(PERF_MAX + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sample_valid,
    input logic signed [COEF_W-1:0] coef_rate,
    input logic signed [COEF_W-1:0] coef_err,
    input logic [PERF_W-1:0]        perf_pct,
    input logic                     perf_valid
);
    assert_perf_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        perf_pct <= PERF_W'(PERF_MAX));

    assert_valid_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> perf_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> !perf_valid);

    assert_hold_between_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(perf_pct));

    assert_zero_gain_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && coef_rate == '0 && coef_err == '0) |=> $stable(perf_pct));
endmodule

bind thermal_throttle_ctrl thr_ctrl_checker #(
    .COEF_W(COEF_W), .PERF_MAX(PERF_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .coef_rate   (coef_rate),
    .coef_err    (coef_err),
    .perf_pct    (perf_pct),
    .perf_valid  (perf_valid)
);

// File: tb/sim_thermal_throttle_ctrl.sv
module sim_thermal_throttle_ctrl;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_valid = 1'b0;
    logic [9:0]        temp_in = '0;
    logic [9:0]        target_temp = '0;
    logic signed [7:0] coef_rate = '0;
    logic signed [7:0] coef_err = '0;
    logic [6:0]        perf_pct;
    logic              perf_valid;

    int checks = 0;
    int errors = 0;
    int perf_m = 100;
    int prev_m = 0;
    bit primed = 0;

    always #10 clk = ~clk;

    thermal_throttle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .temp_in(temp_in), .target_temp(target_temp),
        .coef_rate(coef_rate), .coef_err(coef_err),
        .perf_pct(perf_pct), .perf_valid(perf_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int kval(input int idx);
        case (idx)
            0: return -128; 1: return -17; 2: return -1; 3: return 0;
            4: return 1;    5: return 16;  6: return 37; default: return 127;
        endcase
    endfunction

    // R2 R3 R4 model: SV integer division truncates toward zero
    function automatic int model(input int p, input int t, input int tp,
                                 input int tt, input int k1, input int k2);
        int s;
        int np;
        s  = k1 * (t - tp) + k2 * (t - tt);
        np = p - s / 16;
        if (np < 0) np = 0;
        if (np > 100) np = 100;
        return np;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sample_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 perf during reset", perf_pct, 100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 perf after reset", perf_pct, 100);
        chk("R1 valid after reset", perf_valid, 0);
        perf_m = 100;
        primed = 0;
    endtask

    task automatic strobe(input int t);
        int exp;
        temp_in = 10'(t);
        sample_valid = 1'b1;
        if (!primed) prev_m = t; // R5 first sample serves as previous
        exp = model(perf_m, t, prev_m, int'(target_temp),
                    int'(coef_rate), int'(coef_err));
        @(negedge clk);
        sample_valid = 1'b0;
        chk("R7 valid pulse", perf_valid, 1);
        chk(primed ? "R2 R3 R4 update" : "R5 first update", perf_pct, exp);
        perf_m = exp;
        prev_m = t;
        primed = 1;
        @(negedge clk);
        chk("R7 valid single cycle", perf_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                int tgt;
                do_reset();
                tgt = 300 + a * 50;
                coef_rate = 8'(kval(a));
                coef_err = 8'(kval(b));
                target_temp = 10'(tgt);
                for (int i = 0; i < 10; i++) begin
                    int t;
                    t = tgt + ((i * 37 + a * 11 + b * 5) % 81) - 40;
                    if (i == 6 && (b % 2) == 1) t = 1023;
                    if (i == 7 && (b % 2) == 1) t = 0;
                    strobe(t);
                end
                // R6 R8: disturb inputs without a strobe
                temp_in = 10'(1023 - prev_m);
                coef_rate = 8'(-kval(a) - 1);
                coef_err = 8'(kval(7 - b));
                target_temp = 10'(1000 - tgt);
                repeat (2) @(negedge clk);
                chk("R6 R8 hold without strobe", perf_pct, perf_m);
                chk("R7 no valid without strobe", perf_valid, 0);
                coef_rate = 8'(kval(a));
                coef_err = 8'(kval(b));
                target_temp = 10'(tgt);
                strobe(tgt + 7 - a); // R6 uses last strobed sample
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule